// File: doc/BRIEF.md
# Audio Serial Bit and Frame Clock Generator

This block runs entirely in the master audio clock domain. It divides that clock down to a serial bit clock and a frame (word-select) clock for an audio serial link. It also emits a one-cycle strobe that marks the start of every bit period, so downstream shift logic can advance without watching the bit clock itself. The master-to-bit ratio can be programmed in two ways. A short power-of-two code selects 1, 2, 4 or 8. A wider ratio-minus-one field selects any ratio from 2 to 64, and it wins whenever it is nonzero. The frame length, counted in bit clocks, is programmed separately. Each output clock has its own polarity inversion.

Software writes the configuration only while the divider enable is low. Raising the enable starts both dividers from zero, so the first bit and the first frame have their full length. Lowering the enable parks both clocks at their idle levels on the next master cycle.

Top module: `aud_sclk_gen`

## Requirements
- R1: While the block is not running (the master edge after `div_en` was sampled low), the strobe is 0, `bclk_o` equals `bclk_inv` and `fclk_o` equals `fclk_inv`.
- R2: With `div_ext_m1` = 0, the ratio N is 2 to the power `div_pow2` (code 0..3 gives 1, 2, 4, 8).
- R3: With `div_ext_m1` nonzero, N = `div_ext_m1` + 1 whatever `div_pow2` holds. For N of 2 or more, the uninverted bit clock is low for floor(N/2) master cycles and then high for the rest of each N-cycle bit period.
- R4: With N = 1 the uninverted bit clock follows the master clock while running, and the strobe is high on every master cycle.
- R5: `bit_stb_o` is high for exactly the first master cycle of each bit period.
- R6: A frame lasts `frame_len_m1` + 1 bit periods. The uninverted frame clock is high for the first floor((`frame_len_m1`+1)/2) bit periods and low for the rest, and it changes only at a bit-period start.
- R7: The first master cycle after the enable takes effect is cycle 0 of bit 0 of frame 0. The strobe is high there and the first bit period has full length.
- R8: `bclk_inv` = 1 inverts `bclk_o` in both the running and the idle state.
- R9: `fclk_inv` = 1 inverts `fclk_o` in both the running and the idle state.
- R10: Lowering the enable mid-bit stops the outputs on the next master edge. A later re-enable restarts both dividers from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_en | input | 1 | Divider enable |
| div_pow2 | input | 2 | Power-of-two ratio code |
| div_ext_m1 | input | 6 | Extended ratio minus one; nonzero takes priority |
| frame_len_m1 | input | 12 | Bit clocks per frame minus one |
| bclk_inv | input | 1 | Bit clock polarity invert |
| fclk_inv | input | 1 | Frame clock polarity invert |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| bit_stb_o | output | 1 | One-cycle strobe at the start of each bit period |

## Verification
On every cycle the assertions check four things. The outputs sit at their idle levels while stopped. The strobe falls in the first running cycle after enable and never repeats on back-to-back cycles when N > 1. The frame clock moves only on a strobe cycle. Both counters start from zero after enable. Only the bench's scenarios can show the exact bit-period waveform for each ratio encoding, including the priority of the extended field, the half split of the frame, the inversions, and the unity ratio that follows the master clock. They do this by comparing every master cycle against a waveform derived independently.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Effective master-to-bit ratio: extended field wins when nonzero.
  function automatic int unsigned ratio_of(input int unsigned code,
                                           input int unsigned ext_m1);
    if (ext_m1 != 0) return ext_m1 + 1;
    return 1 << code;
  endfunction

  // Number of leading units spent low (bit) or high (frame).
  function automatic int unsigned half_of(input int unsigned n);
    return n >> 1;
  endfunction

endpackage

// File: rtl/aclk_ratio_sel.sv
module aclk_ratio_sel #(
  parameter int POW_W = 2,
  parameter int EXT_W = 6,
  parameter int RAT_W = EXT_W + 1
) (
  input  logic [POW_W-1:0] pow2_code,
  input  logic [EXT_W-1:0] ext_m1,
  output logic [RAT_W-1:0] ratio,
  output logic             is_unity
);
  always_comb begin
    ratio    = RAT_W'(aclk_pkg::ratio_of(int'(pow2_code), int'(ext_m1)));
    is_unity = (ratio == RAT_W'(1));
  end
endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int RAT_W = 7
) (
  input  logic             clk_m,
  input  logic             rst_n,
  input  logic             run,
  input  logic [RAT_W-1:0] ratio,
  input  logic             is_unity,
  output logic             bit_stb,
  output logic             bit_last,
  output logic             bclk_raw
);
  logic [RAT_W-1:0] cnt_q;
  logic [RAT_W-1:0] half;

  always_comb begin
    half     = RAT_W'(aclk_pkg::half_of(int'(ratio)));
    bit_last = (cnt_q == ratio - RAT_W'(1));
    bit_stb  = run && (cnt_q == '0);
    if (!run)          bclk_raw = 1'b0;
    else if (is_unity) bclk_raw = clk_m;
    else               bclk_raw = (cnt_q >= half);
  end

  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (bit_last) cnt_q <= '0;
    else               cnt_q <= cnt_q + RAT_W'(1);
  end

  // R5: with ratio above one, strobes never fall on adjacent cycles
  a_r5_stb_spacing: assert property (@(posedge clk_m) disable iff (!rst_n)
    (bit_stb && !is_unity && run) |=> !bit_stb);
endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
  parameter int FRM_W = 12
) (
  input  logic             clk_m,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_last,
  input  logic [FRM_W-1:0] frame_m1,
  output logic             fclk_raw,
  output logic             frame_zero
);
  localparam int LEN_W = FRM_W + 1;
  logic [FRM_W-1:0] cnt_q;
  logic [LEN_W-1:0] frame_len;
  logic [LEN_W-1:0] high_bits;

  always_comb begin
    frame_len  = {1'b0, frame_m1} + LEN_W'(1);
    high_bits  = LEN_W'(aclk_pkg::half_of(int'(frame_len)));
    fclk_raw   = run && ({1'b0, cnt_q} < high_bits);
    frame_zero = (cnt_q == '0);
  end

  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (bit_last)  cnt_q <= (cnt_q == frame_m1) ? '0 : cnt_q + FRM_W'(1);
  end
endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen #(
  parameter int POW_W = 2,
  parameter int EXT_W = 6,
  parameter int FRM_W = 12
) (
  input  logic             clk_m,
  input  logic             rst_n,
  input  logic             div_en,
  input  logic [POW_W-1:0] div_pow2,
  input  logic [EXT_W-1:0] div_ext_m1,
  input  logic [FRM_W-1:0] frame_len_m1,
  input  logic             bclk_inv,
  input  logic             fclk_inv,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             bit_stb_o
);
  localparam int RAT_W = EXT_W + 1;

  logic             run_q;
  logic [RAT_W-1:0] ratio;
  logic             is_unity;
  logic             bit_stb;
  logic             bit_last;
  logic             bclk_raw;
  logic             fclk_raw;
  logic             frame_zero;

  always_ff @(posedge clk_m or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= div_en;
  end

  aclk_ratio_sel #(.POW_W(POW_W), .EXT_W(EXT_W), .RAT_W(RAT_W)) u_ratio (
    .pow2_code(div_pow2), .ext_m1(div_ext_m1),
    .ratio(ratio), .is_unity(is_unity));

  aclk_bit_div #(.RAT_W(RAT_W)) u_bit (
    .clk_m(clk_m), .rst_n(rst_n), .run(run_q), .ratio(ratio),
    .is_unity(is_unity), .bit_stb(bit_stb), .bit_last(bit_last),
    .bclk_raw(bclk_raw));

  aclk_frame_div #(.FRM_W(FRM_W)) u_frame (
    .clk_m(clk_m), .rst_n(rst_n), .run(run_q), .bit_last(bit_last),
    .frame_m1(frame_len_m1), .fclk_raw(fclk_raw), .frame_zero(frame_zero));

  assign bclk_o    = bclk_raw ^ bclk_inv;
  assign fclk_o    = fclk_raw ^ fclk_inv;
  assign bit_stb_o = bit_stb;

  // R1: stopped outputs rest at the polarity levels
  a_r1_idle_levels: assert property (@(posedge clk_m) disable iff (!rst_n)
    !run_q |-> (!bit_stb_o && (fclk_o == fclk_inv)));

  // R7: first running cycle opens a bit period
  a_r7_first_strobe: assert property (@(posedge clk_m) disable iff (!rst_n)
    $rose(run_q) |-> bit_stb_o);

  // R10: re-enable restarts the frame counter from zero
  a_r10_restart_zero: assert property (@(posedge clk_m) disable iff (!rst_n)
    $rose(run_q) |-> frame_zero);

  // R6: the frame clock moves only at a bit-period start
  a_r6_frame_on_strobe: assert property (@(posedge clk_m) disable iff (!rst_n)
    (run_q && $past(run_q) && !bit_stb) |-> $stable(fclk_raw));
endmodule

// File: tb/aud_sclk_gen_tb.sv
module aud_sclk_gen_tb;
  logic        clk_m = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_en = 1'b0;
  logic [1:0]  div_pow2 = '0;
  logic [5:0]  div_ext_m1 = '0;
  logic [11:0] frame_len_m1 = 12'd63;
  logic        bclk_inv = 1'b0;
  logic        fclk_inv = 1'b0;
  logic        bclk_o, fclk_o, bit_stb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_m = ~clk_m;

  aud_sclk_gen u_dut (
    .clk_m(clk_m), .rst_n(rst_n), .div_en(div_en), .div_pow2(div_pow2),
    .div_ext_m1(div_ext_m1), .frame_len_m1(frame_len_m1),
    .bclk_inv(bclk_inv), .fclk_inv(fclk_inv),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .bit_stb_o(bit_stb_o));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_m); #1;
  endtask

  task automatic chk_idle(input string req);
    chk(req, "idle strobe", int'(bit_stb_o), 0);
    chk(req, "idle bclk", int'(bclk_o), int'(bclk_inv));
    chk(req, "idle fclk", int'(fclk_o), int'(fclk_inv));
  endtask

  // Configure while stopped, run ncyc cycles comparing every cycle, then stop.
  task automatic run_cfg(input logic [1:0] code, input logic [5:0] ext,
                         input logic [11:0] fm1, input logic bi, input logic fi,
                         input int ncyc, input string tag_b, input string tag_f);
    int n;
    int flen;
    step();
    div_en = 1'b0;
    div_pow2 = code; div_ext_m1 = ext; frame_len_m1 = fm1;
    bclk_inv = bi; fclk_inv = fi;
    step();
    chk_idle("R1");
    if (ext != 0) n = int'(ext) + 1;
    else case (code)
      2'd0: n = 1;
      2'd1: n = 2;
      2'd2: n = 4;
      default: n = 8;
    endcase
    flen = int'(fm1) + 1;
    div_en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      int b;
      int fb;
      logic eb;
      logic ef;
      step();
      b  = i % n;
      fb = (i / n) % flen;
      eb = (n == 1) ? 1'b0 : (2 * b + 1 >= n);
      ef = (2 * fb + 1 <= int'(fm1));
      if (i == 0) chk("R7", "first strobe", int'(bit_stb_o), 1);
      chk("R5", "strobe", int'(bit_stb_o), int'(b == 0));
      chk(tag_b, "bclk", int'(bclk_o), int'(eb ^ bi));
      chk(tag_f, "fclk", int'(fclk_o), int'(ef ^ fi));
    end
    div_en = 1'b0;
    step();
    chk_idle("R10");
  endtask

  task automatic t_reset();
    chk_idle("R1");
  endtask

  task automatic t_legacy();
    run_cfg(2'd1, 6'd0, 12'd3, 1'b0, 1'b0, 2 * 4 * 2 + 1, "R2", "R6");
    run_cfg(2'd2, 6'd0, 12'd3, 1'b0, 1'b0, 4 * 4 * 2 + 1, "R2", "R6");
    run_cfg(2'd3, 6'd0, 12'd3, 1'b0, 1'b0, 8 * 4 * 2 + 1, "R2", "R6");
  endtask

  task automatic t_unity();
    run_cfg(2'd0, 6'd0, 12'd3, 1'b0, 1'b0, 12, "R4", "R6");
    div_en = 1'b1;
    step();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_m); #1;
      chk("R4", "unity bclk high phase", int'(bclk_o), 1);
      chk("R4", "unity strobe", int'(bit_stb_o), 1);
      @(negedge clk_m); #1;
      chk("R4", "unity bclk low phase", int'(bclk_o), 0);
    end
    div_en = 1'b0;
    step();
    step();
    chk_idle("R1");
  endtask

  task automatic t_extended();
    run_cfg(2'd0, 6'd2, 12'd3, 1'b0, 1'b0, 3 * 4 * 2, "R3", "R6");
    run_cfg(2'd1, 6'd5, 12'd2, 1'b0, 1'b0, 6 * 3 * 2, "R3", "R6");
    run_cfg(2'd3, 6'd63, 12'd1, 1'b0, 1'b0, 64 * 2 * 2, "R3", "R6");
  endtask

  task automatic t_frame();
    run_cfg(2'd1, 6'd0, 12'd63, 1'b0, 1'b0, 2 * 64 * 2 + 4, "R2", "R6");
    run_cfg(2'd2, 6'd0, 12'd4, 1'b0, 1'b0, 4 * 5 * 2, "R2", "R6");
    run_cfg(2'd1, 6'd0, 12'd0, 1'b0, 1'b0, 10, "R2", "R6");
  endtask

  task automatic t_polarity();
    run_cfg(2'd2, 6'd0, 12'd3, 1'b1, 1'b0, 4 * 4 * 2, "R8", "R9");
    run_cfg(2'd2, 6'd0, 12'd3, 1'b0, 1'b1, 4 * 4 * 2, "R8", "R9");
    run_cfg(2'd0, 6'd2, 12'd5, 1'b1, 1'b1, 3 * 6 * 2, "R8", "R9");
  endtask

  task automatic t_restart();
    run_cfg(2'd3, 6'd0, 12'd3, 1'b0, 1'b0, 13, "R10", "R10");
    run_cfg(2'd3, 6'd0, 12'd3, 1'b0, 1'b0, 8 * 4 + 3, "R10", "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_m);
    #1;
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_legacy();
    t_unity();
    t_extended();
    t_frame();
    t_polarity();
    t_restart();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_m);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule